// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor Core

This core executes programs made of a single instruction kind. Each instruction is one 32-bit word in a unified, word-addressed memory. The upper half of the word is a branch target and the lower half is an operand address. The core reads the operand word and subtracts its 32-bit accumulator from it. It writes the difference to the same memory word and also keeps it in the accumulator. If the difference, read as a two's-complement number, is zero or negative, the program counter takes the branch target. Otherwise it moves on to the next word.

The core drives one single-port synchronous memory. Read data returns one cycle after the address is presented. Each instruction takes three bus cycles: instruction fetch, operand read, and result write. A program signals that it is finished by executing a taken branch to its own address. The core then halts and holds the bus idle until the next reset. Writes that land in the 256-word display window starting at word 0x400 are also copied to a separate strobe with a window-relative offset, so a frame buffer or an observer can follow them.

Top module: `subl_core`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator is cleared to 0, the program counter is loaded from `start_addr` and `halted` goes low. The first bus cycle after reset is a fetch from `start_addr`.
- R2: An instruction word is split into a branch target in bits 31..16 and an operand address in bits 15..0. The cycle after the fetch puts the operand address (bits 15..0 of the fetched word) on `mem_addr`.
- R3: In the write cycle, `mem_we` is 1, `mem_addr` holds the operand address, and `mem_wdata` equals the operand word minus the accumulator, modulo 2^32. The accumulator takes that same value.
- R4: When the result has bit 31 set or equals zero, the next fetch address is the branch target.
- R5: When the result is positive, the next fetch address is the current address plus 1, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R6: Each instruction takes exactly three cycles, in this order: fetch with address = PC, operand read, and write. `mem_we` is high only in the third cycle. The memory returns read data one cycle after the address.
- R7: A taken branch whose target equals the address of the instruction itself sets `halted` after that instruction's write. From then until reset, `halted` stays 1, no further fetch takes place and `mem_we` stays 0.
- R8: Every write to word address 0x400..0x4FF raises `disp_we` in the same cycle. `disp_addr` carries the address minus 0x400 and `disp_data` carries the written data. Writes to any other address leave `disp_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | 16 | Entry address loaded into the program counter at reset |
| mem_addr | output | 16 | Word address to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Read data from memory, valid one cycle after the address |
| halted | output | 1 | High once the program has branched to itself |
| disp_we | output | 1 | Write strobe for the display window |
| disp_addr | output | 8 | Word offset inside the display window |
| disp_data | output | 32 | Data written to the display window |

## Verification
A wrong accumulator value first appears in the `mem_wdata` of the next write cycle, at most three cycles later. From then on it also changes the branch decision. A wrong program counter or a misread field shows up one or two cycles later, as an unexpected address in a fetch or operand-read cycle. The bench compares every bus cycle against an instruction-level model and localizes each divergence to the instruction where it began. A broken halt condition shows up as a fetch past the expected end of the program, or as a missing halt.

// File: rtl/subl_pkg.sv
package subl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 2 * ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // instruction word: target in the high half, operand address in the low half
    typedef struct packed {
        addr_t tgt;
        addr_t opnd;
    } instr_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_OPND  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_HALT  = 2'd3
    } phase_e;

    // two's-complement zero-or-negative test
    function automatic logic not_positive(input word_t v);
        return v[DATA_W-1] || (v == '0);
    endfunction

endpackage

// File: rtl/subl_alu.sv
module subl_alu
    import subl_pkg::*;
(
    input  word_t opnd_val,
    input  word_t acc,
    output word_t diff,
    output logic  take
);
    always_comb begin
        diff = opnd_val - acc;
        take = not_positive(diff);
    end
endmodule

// File: rtl/subl_seq.sv
module subl_seq
    import subl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t start_addr,
    input  word_t rdata,
    input  logic  take,
    output addr_t bus_addr,
    output logic  bus_we,
    output logic  halted
);
    phase_e st;
    addr_t  pc;
    instr_t ins_q;
    instr_t ins_now;

    assign ins_now = instr_t'(rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_FETCH;
            pc     <= start_addr;
            ins_q  <= '0;
            halted <= 1'b0;
        end else begin
            unique case (st)
                ST_FETCH: st <= ST_OPND;
                ST_OPND: begin
                    ins_q <= ins_now;
                    st    <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (take && (ins_q.tgt == pc)) begin
                        halted <= 1'b1;
                        st     <= ST_HALT;
                    end else begin
                        pc <= take ? ins_q.tgt : pc + 1'b1;
                        st <= ST_FETCH;
                    end
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    always_comb begin
        bus_addr = pc;
        bus_we   = 1'b0;
        unique case (st)
            ST_OPND: bus_addr = ins_now.opnd;
            ST_EXEC: begin
                bus_addr = ins_q.opnd;
                bus_we   = 1'b1;
            end
            default: bus_addr = pc;
        endcase
    end

    // R1: reset loads the entry address and clears the halt flag
    a_r1_reset_load: assert property (@(posedge clk)
        rst |=> (pc == $past(start_addr) && !halted && st == ST_FETCH));

    // R6: a write cycle is never followed directly by another write
    a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);

    // R4: a taken branch moves the program counter to the target
    a_r4_taken: assert property (@(posedge clk) disable iff (rst)
        (bus_we && take) |=> (pc == $past(ins_q.tgt)));

    // R5: a positive result steps to the next word, wrapping at the top
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !take) |=> (pc == $past(pc) + 1'b1));

    // R7: once halted, stay halted and quiet on the bus
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !bus_we));
endmodule

// File: rtl/subl_disp_tap.sv
module subl_disp_tap
    import subl_pkg::*;
#(
    parameter int unsigned BASE  = 32'h0400,
    parameter int unsigned WORDS = 256,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  addr_t             addr,
    input  word_t             wdata,
    input  logic              we,
    output logic              tap_we,
    output logic [OFF_W-1:0]  tap_addr,
    output word_t             tap_data
);
    localparam addr_t BASE_A  = addr_t'(BASE);
    localparam addr_t WORDS_A = addr_t'(WORDS);

    addr_t off;
    logic  in_win;

    always_comb begin
        off      = addr - BASE_A;
        in_win   = (addr >= BASE_A) && (off < WORDS_A);
        tap_we   = we && in_win;
        tap_addr = off[OFF_W-1:0];
        tap_data = wdata;
    end
endmodule

// File: rtl/subl_core.sv
module subl_core
    import subl_pkg::*;
#(
    parameter int unsigned DISP_BASE  = 32'h0400,
    parameter int unsigned DISP_WORDS = 256,
    localparam int DISP_AW = $clog2(DISP_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  start_addr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               halted,
    output logic               disp_we,
    output logic [DISP_AW-1:0] disp_addr,
    output logic [DATA_W-1:0]  disp_data
);
    word_t acc_q;
    word_t diff;
    logic  take;

    subl_alu u_alu (
        .opnd_val (mem_rdata),
        .acc      (acc_q),
        .diff     (diff),
        .take     (take)
    );

    subl_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_addr (start_addr),
        .rdata      (mem_rdata),
        .take       (take),
        .bus_addr   (mem_addr),
        .bus_we     (mem_we),
        .halted     (halted)
    );

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '0;
        else if (mem_we) acc_q <= diff;
    end

    assign mem_wdata = diff;

    subl_disp_tap #(
        .BASE  (DISP_BASE),
        .WORDS (DISP_WORDS)
    ) u_tap (
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .we       (mem_we),
        .tap_we   (disp_we),
        .tap_addr (disp_addr),
        .tap_data (disp_data)
    );

    // R3: the accumulator keeps the value that was written to memory
    a_r3_acc_tracks: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (acc_q == $past(mem_wdata)));

    // R1: accumulator is zero after reset
    a_r1_acc_clear: assert property (@(posedge clk)
        rst |=> (acc_q == '0));

    // R8: the display strobe only fires together with a memory write
    a_r8_disp_with_write: assert property (@(posedge clk) disable iff (rst)
        disp_we |-> (mem_we && disp_data == mem_wdata));
endmodule

// File: tb/subl_core_tb.sv
module subl_core_tb;
    localparam int MW = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] start_addr = 16'h0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] mem_rdata;
    logic        halted;
    logic        disp_we;
    logic [7:0]  disp_addr;
    logic [31:0] disp_data;

    always #5 clk = ~clk;

    subl_core u_dut (
        .clk(clk), .rst(rst), .start_addr(start_addr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .halted(halted),
        .disp_we(disp_we), .disp_addr(disp_addr), .disp_data(disp_data)
    );

    // synchronous single-port memory, one-cycle read latency, aliased to 2048 words
    logic [31:0] ram [MW];
    logic [31:0] rm  [MW];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[10:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[10:0]];
    end

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    logic [15:0] fetch_q[$];
    logic [15:0] opnd_q[$];
    logic [47:0] wr_q[$];
    int phase = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: samples on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst) phase = 0;
        else if (phase == 0) begin
            if (halted) begin
                if (mem_we) chk(1'b0, "R7", "write while halted", 48'(mem_we), 48'd0);
            end else if (fetch_q.size() == 0) begin
                chk(1'b0, "R7", "fetch past halt", 48'(mem_addr), 48'hx);
                phase = 1;
            end else begin
                logic [15:0] e;
                e = fetch_q.pop_front();
                chk(mem_addr == e && !mem_we, "R4/R5/R6", "fetch addr",
                    48'(mem_addr), 48'(e));
                phase = 1;
            end
        end else if (phase == 1) begin
            logic [15:0] e;
            e = (opnd_q.size() != 0) ? opnd_q.pop_front() : 16'hxxxx;
            chk(mem_addr == e && !mem_we, "R2", "operand read addr",
                48'(mem_addr), 48'(e));
            phase = 2;
        end else begin
            logic [47:0] e;
            logic        in_win;
            e = (wr_q.size() != 0) ? wr_q.pop_front() : 48'hx;
            chk(mem_we === 1'b1 && {mem_addr, mem_wdata} === e, "R3", "write cycle",
                {mem_addr, mem_wdata}, e);
            in_win = (e[47:32] >= 16'h0400) && (e[47:32] <= 16'h04FF);
            if (in_win)
                chk(disp_we && disp_addr == e[39:32] && disp_data == e[31:0], "R8",
                    "display tap", {7'd0, disp_we, disp_addr, disp_data},
                    {7'd0, 1'b1, e[39:32], e[31:0]});
            else
                chk(!disp_we, "R8", "tap outside window", 48'(disp_we), 48'd0);
            phase = 0;
        end
    end

    task automatic clr();
        for (int i = 0; i < MW; i++) begin ram[i] = '0; rm[i] = '0; end
    endtask

    task automatic put(input logic [15:0] a, input logic [31:0] w);
        ram[a[10:0]] = w;
        rm[a[10:0]]  = w;
    endtask

    task automatic ins(input logic [15:0] a, input logic [15:0] t, input logic [15:0] o);
        put(a, {t, o});
    endtask

    // driver: instruction-level model from the requirements, pushes expected bus items
    task automatic run(input logic [15:0] start, input string name);
        logic [15:0] pc;
        logic [31:0] acc, w, r;
        bit halt_exp, le;
        int steps, miss;
        halt_exp = 0;
        pc = start;
        acc = '0;
        steps = 0;
        @(posedge clk); #1;
        rst = 1'b1;
        start_addr = start;
        fetch_q.delete(); opnd_q.delete(); wr_q.delete();
        for (int s = 0; s < 400; s++) begin
            w = rm[pc[10:0]];
            fetch_q.push_back(pc);
            opnd_q.push_back(w[15:0]);
            r = rm[w[10:0]] - acc;
            rm[w[10:0]] = r;
            acc = r;
            wr_q.push_back({w[15:0], r});
            steps++;
            le = r[31] || (r == 32'd0);
            if (le && w[31:16] == pc) begin halt_exp = 1; break; end
            pc = le ? w[31:16] : pc + 16'd1;
        end
        chk(halt_exp, "R7", {"model halts: ", name}, 48'(halt_exp), 48'd1);
        @(posedge clk); @(negedge clk);
        // R1: state during reset
        chk(mem_addr == start && !mem_we && !halted, "R1", {"reset state ", name},
            {15'd0, halted, mem_we, 15'd0, mem_addr}, {32'd0, start});
        @(posedge clk); #1;
        rst = 1'b0;
        for (int c = 0; c < 3 * steps + 10; c++) begin
            @(posedge clk);
            if (halted) break;
        end
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(halted, "R7", {"halted at end ", name}, 48'(halted), 48'd1);
        chk(fetch_q.size() == 0 && wr_q.size() == 0, "R6", {"all cycles seen ", name},
            48'(wr_q.size()), 48'd0);
        miss = 0;
        for (int i = 0; i < MW; i++) if (ram[i] !== rm[i]) miss++;
        chk(miss == 0, "R3", {"final memory ", name}, 48'(miss), 48'd0);
    endtask

    initial begin
        // display writes; ends halted with a negative accumulator
        clr();
        put(16'h03FF, 32'h1111_1111);
        put(16'h04FF, 32'h1234_5678);
        put(16'h0500, 32'h0000_0005);
        put(16'h0060, 32'h8000_0000);
        ins(16'h0010, 16'h0011, 16'h03FF);
        ins(16'h0011, 16'h0012, 16'h0400);
        ins(16'h0012, 16'h0013, 16'h04FF);
        ins(16'h0013, 16'h0014, 16'h0500);
        ins(16'h0014, 16'h0015, 16'h0061);
        ins(16'h0015, 16'h0016, 16'h0061);
        ins(16'h0016, 16'h0016, 16'h0060);
        run(16'h0010, "display");

        // R1: accumulator must be cleared by reset for this result to match
        clr();
        put(16'h0000, 32'd5);
        put(16'h0001, 32'd3);
        ins(16'h0003, 16'h0004, 16'h0002);
        ins(16'h0004, 16'h0005, 16'h0000);
        ins(16'h0005, 16'h0006, 16'h0002);
        ins(16'h0006, 16'h0007, 16'h0001);
        ins(16'h0007, 16'h0008, 16'h0020);
        ins(16'h0008, 16'h0008, 16'h0020);
        run(16'h0003, "acc reset");

        // R4/R5 sign boundaries: 0x80000000 taken, zero taken, 0x7FFFFFFF not taken
        clr();
        put(16'h0000, 32'h8000_0000);
        put(16'h0001, 32'h7FFF_FFFF);
        ins(16'h0003, 16'h0010, 16'h0000);
        ins(16'h0010, 16'h0011, 16'h0020);
        ins(16'h0011, 16'h0018, 16'h0020);
        ins(16'h0018, 16'h0040, 16'h0001);
        ins(16'h0019, 16'h001A, 16'h0021);
        ins(16'h001A, 16'h001A, 16'h0021);
        run(16'h0003, "sign");

        // R5 wrap: fall through from 0xFFFF to 0x0000
        clr();
        put(16'h0001, 32'd7);
        ins(16'hFFFF, 16'h0100, 16'h0001);
        ins(16'h0000, 16'h0050, 16'h0021);
        ins(16'h0050, 16'h0051, 16'h0022);
        ins(16'h0051, 16'h0051, 16'h0022);
        run(16'hFFFF, "wrap");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule